// File: doc/BRIEF.md
# Dual-channel interrupt status combiner

This block collects the transmit-ready and receive-ready conditions of two serial channels (A and B) into a single status byte. It keeps an enable mask and drives one active-high interrupt line shared by both channels. The line is high when any ready condition is set and its enable bit is also set. The serial datapaths are outside this block. Each channel supplies its two ready conditions as plain level inputs, and the block registers them before use.

A byte-wide register port reaches the block at one address, 0x14. A read at that address returns the live status. A write at that address loads the enable mask. Each channel has a slot of four bits: channel A uses bits 0 and 1, and channel B uses bits 4 and 5. The enable mask uses the same layout, so that software can service channel A first and then channel B from one status read. The channel count, the slot stride, the widths, the address and the depth of the input register are all parameters.

Top module: `isc_irq_combiner`

## Requirements
- R1: A read at address 0x14 returns the registered ready inputs with this layout: bit 0 = channel A transmit-ready, bit 1 = channel A receive-ready, bit 4 = channel B transmit-ready, bit 5 = channel B receive-ready. With the default single input stage, the read shows an input one clock edge after that input changes.
- R2: Status bits 2, 3, 6 and 7 always read as zero.
- R3: A write at address 0x14 loads the enable mask at the clock edge. The mask uses the same bit layout as the status byte.
- R4: Reset clears the enable mask, so `irq` stays low after reset even when every ready input is high.
- R5: `irq` is the OR of (status AND mask) over all bits. There is no further register between the status and mask registers and `irq`, so `irq` follows a ready input after the same edge that makes the input visible in the status byte.
- R6: A write to any address other than 0x14 leaves the enable mask unchanged.
- R7: Writes do not clear status bits. The status byte always reflects the current ready inputs, whatever value was written.
- R8: `reg_rdata` is zero unless a read at address 0x14 is in progress.
- R9: Each enable bit gates only its own status bit. For example, enabling only channel B receive-ready raises `irq` for that condition alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_tx_ready | input | NUM_CH (2) | Transmit-ready level per channel, index 0 = A |
| chan_rx_ready | input | NUM_CH (2) | Receive-ready level per channel, index 0 = A |
| reg_sel | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (6) | Register byte address |
| reg_wdata | input | DATA_W (8) | Write data (enable mask) |
| reg_rdata | output | DATA_W (8) | Read data (status) |
| irq | output | 1 | Shared active-high interrupt |

## Verification
The bench builds the block with its default parameters: two channels, a four-bit stride, an eight-bit register, address 0x14 and one input stage. This configuration exercises the exact split of the bit positions between channel A and channel B, and the one-edge latency from a ready input to both the status byte and `irq`. It also places the unused bit positions 2, 3, 6 and 7 between the used ones, so the bench can check that they always read zero and that no enable bit is routed to the wrong channel.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int TX_SLOT = 0;
   localparam int RX_SLOT = 1;
   localparam int MAX_W   = 64;

   // Bit positions that carry a ready condition for the given layout
   function automatic logic [MAX_W-1:0] ready_bit_mask(input int num_ch, input int stride);
      logic [MAX_W-1:0] m;
      m = '0;
      for (int c = 0; c < num_ch; c++) begin
         m[c*stride + TX_SLOT] = 1'b1;
         m[c*stride + RX_SLOT] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/isc_ready_sync.sv
module isc_ready_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= '0;
            else        pipe[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/isc_status_pack.sv
module isc_status_pack #(
   parameter int NUM_CH    = 2,
   parameter int CH_STRIDE = 4,
   parameter int DATA_W    = 8
) (
   input  logic [NUM_CH-1:0] tx_q,
   input  logic [NUM_CH-1:0] rx_q,
   output logic [DATA_W-1:0] status
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int CH   = b / CH_STRIDE;
      localparam int SLOT = b % CH_STRIDE;
      if (CH < NUM_CH && SLOT == isc_pkg::TX_SLOT) begin : g_tx
         assign status[b] = tx_q[CH];
      end else if (CH < NUM_CH && SLOT == isc_pkg::RX_SLOT) begin : g_rx
         assign status[b] = rx_q[CH];
      end else begin : g_zero
         assign status[b] = 1'b0;
      end
   end
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
   parameter int              DATA_W = 8,
   parameter logic [DATA_W-1:0] KEEP = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din & KEEP;
   end
endmodule

// File: rtl/isc_irq_combiner.sv
module isc_irq_combiner #(
   parameter int NUM_CH      = 2,
   parameter int CH_STRIDE   = 4,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 6,
   parameter int STATUS_ADDR = 'h14,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] chan_tx_ready,
   input  logic [NUM_CH-1:0] chan_rx_ready,
   input  logic              reg_sel,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam logic [DATA_W-1:0] USED_MASK =
      DATA_W'(isc_pkg::ready_bit_mask(NUM_CH, CH_STRIDE));
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STATUS_ADDR);

   if (NUM_CH < 1)                    begin : g_bad_ch     $error("NUM_CH must be at least 1"); end
   if (CH_STRIDE < 2)                 begin : g_bad_stride $error("CH_STRIDE must hold two slots"); end
   if (NUM_CH * CH_STRIDE > DATA_W)   begin : g_bad_width  $error("layout exceeds DATA_W"); end
   if (DATA_W > isc_pkg::MAX_W)       begin : g_bad_dw     $error("DATA_W too large"); end
   if (SYNC_STAGES < 1)               begin : g_bad_sync   $error("SYNC_STAGES must be at least 1"); end
   if (STATUS_ADDR >= (1 << ADDR_W))  begin : g_bad_addr   $error("STATUS_ADDR out of range"); end

   logic [NUM_CH-1:0] tx_q, rx_q;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] mask_q;
   logic              addr_hit, rd_hit, wr_hit;

   assign addr_hit = reg_sel && (reg_addr == HIT_ADDR);
   assign rd_hit   = addr_hit && !reg_write;
   assign wr_hit   = addr_hit && reg_write;

   isc_ready_sync #(.WIDTH(2*NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({chan_rx_ready, chan_tx_ready}),
      .dout ({rx_q, tx_q})
   );

   isc_status_pack #(.NUM_CH(NUM_CH), .CH_STRIDE(CH_STRIDE), .DATA_W(DATA_W)) u_pack (
      .tx_q  (tx_q),
      .rx_q  (rx_q),
      .status(status_q)
   );

   isc_mask_reg #(.DATA_W(DATA_W), .KEEP(USED_MASK)) u_mask (
      .clk  (clk),
      .rst_n(rst_n),
      .load (wr_hit),
      .din  (reg_wdata),
      .q    (mask_q)
   );

   assign irq       = |(status_q & mask_q);
   assign reg_rdata = rd_hit ? status_q : '0;
endmodule

// File: rtl/isc_irq_combiner_chk.sv
module isc_irq_combiner_chk #(
   parameter int NUM_CH      = 2,
   parameter int CH_STRIDE   = 4,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 6,
   parameter int STATUS_ADDR = 'h14,
   parameter int SYNC_STAGES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] chan_tx_ready,
   input logic [NUM_CH-1:0] chan_rx_ready,
   input logic              reg_sel,
   input logic              reg_write,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq,
   input logic [DATA_W-1:0] mask_q
);
   localparam logic [DATA_W-1:0] USED =
      DATA_W'(isc_pkg::ready_bit_mask(NUM_CH, CH_STRIDE));
   localparam logic [ADDR_W-1:0] A = ADDR_W'(STATUS_ADDR);

   logic rd, wr;
   assign rd = reg_sel && !reg_write && (reg_addr == A);
   assign wr = reg_sel &&  reg_write && (reg_addr == A);

   if (SYNC_STAGES == 1) begin : g_lat
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         a_r1_status_layout: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && $past(rst_n)) |->
               (reg_rdata[k*CH_STRIDE]   == $past(chan_tx_ready[k]) &&
                reg_rdata[k*CH_STRIDE+1] == $past(chan_rx_ready[k])));
      end
   end

   a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~USED) == '0);

   a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (mask_q == ($past(reg_wdata) & USED)));

   a_r4_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !irq);

   a_r5_irq_from_status: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> (irq == |(reg_rdata & mask_q)));

   a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr)) |-> $stable(mask_q));

   a_r8_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> (reg_rdata == '0));
endmodule

bind isc_irq_combiner isc_irq_combiner_chk #(
   .NUM_CH(NUM_CH), .CH_STRIDE(CH_STRIDE), .DATA_W(DATA_W),
   .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_tx_ready(chan_tx_ready), .chan_rx_ready(chan_rx_ready),
   .reg_sel(reg_sel), .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .irq(irq), .mask_q(mask_q)
);

// File: tb/tb_isc_irq_combiner.sv
`timescale 1ns/1ps
module tb_isc_irq_combiner;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] ST_ADDR = 6'h14;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] tx_rdy = '0, rx_rdy = '0;
   logic       sel = 1'b0, wr = 1'b0;
   logic [5:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   isc_irq_combiner dut (
      .clk(clk), .rst_n(rst_n), .chan_tx_ready(tx_rdy), .chan_rx_ready(rx_rdy),
      .reg_sel(sel), .reg_write(wr), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq(irq)
   );

   function automatic logic [7:0] exp_status(logic [1:0] t, logic [1:0] r);
      return {2'b00, r[1], t[1], 2'b00, r[0], t[0]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic set_ready(logic [1:0] t, logic [1:0] r);
      @(negedge clk); tx_rdy = t; rx_rdy = r;
      @(posedge clk); #1;
   endtask

   task automatic bus_write(logic [5:0] a, logic [7:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(logic [5:0] a, output logic [7:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(posedge clk); #1;
      sel = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      tx_rdy = 2'b11; rx_rdy = 2'b11;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R4 irq low after reset", irq, 0);
      bus_read(ST_ADDR, d);
      check("R1 status all ready", d, 8'h33);
   endtask

   task automatic t_layout();
      logic [7:0] d;
      for (int p = 0; p < 16; p += 5) begin
         set_ready(p[1:0], p[3:2]);
         bus_read(ST_ADDR, d);
         check("R1 status layout", d, exp_status(p[1:0], p[3:2]));
         check("R2 unused bits zero", d & 8'hCC, 0);
      end
   endtask

   task automatic t_each_enable();
      for (int b = 0; b < 4; b++) begin
         logic [7:0] bitv;
         logic [3:0] own, other;
         bitv = 8'h01 << ((b / 2) * 4 + (b % 2));
         bus_write(ST_ADDR, bitv);
         own = 4'b0001 << b;
         other = ~own;
         set_ready({own[2], own[0]}, {own[3], own[1]});
         check("R9 own source raises irq", irq, 1);
         set_ready({other[2], other[0]}, {other[3], other[1]});
         check("R9 other sources ignored", irq, 0);
      end
   endtask

   task automatic t_latency();
      bus_write(ST_ADDR, 8'h20);
      set_ready(2'b00, 2'b00);
      @(negedge clk); rx_rdy = 2'b10;
      #1 check("R5 irq before edge", irq, 0);
      @(posedge clk); #1;
      check("R5 irq after one edge", irq, 1);
      bus_write(ST_ADDR, 8'h00);
      check("R3 mask cleared drops irq", irq, 0);
   endtask

   task automatic t_other_addr();
      logic [7:0] d;
      bus_write(ST_ADDR, 8'h00);
      set_ready(2'b11, 2'b11);
      bus_write(6'h10, 8'hFF);
      check("R6 foreign write leaves mask", irq, 0);
      bus_write(6'h34, 8'hFF);
      check("R6 second foreign write", irq, 0);
      bus_read(6'h10, d);
      check("R8 foreign read zero", d, 0);
      #1 check("R8 idle rdata zero", rdata, 0);
   endtask

   task automatic t_live();
      logic [7:0] d;
      set_ready(2'b01, 2'b10);
      bus_write(ST_ADDR, 8'hFF);
      bus_read(ST_ADDR, d);
      check("R7 write does not clear status", d, 8'h21);
      check("R3 full mask irq high", irq, 1);
      bus_write(ST_ADDR, 8'h12);
      check("R3 mask missing both sources", irq, 0);
   endtask

   initial begin
      t_reset();
      t_layout();
      t_each_enable();
      t_latency();
      t_other_addr();
      t_live();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule